// File: doc/BRIEF.md
# Configuration Space Slot Scanner

The block walks the configuration space of every bus and device slot, looking only at function 0. It issues one configuration request at a time over a simple request/response port, which carries bus, device, function and register-offset fields and a 32-bit data path. For each slot it first checks whether a device answers. When one does, it collects the identifiers, the header-type byte, the class code and the revision. It then sizes each base address register with a save / all-ones / read-mask / restore sequence and reads the interrupt line.

Each discovered device produces one record on an output port, marked by a single-cycle valid strobe. Empty slots produce nothing. A start pulse launches the scan. A busy level covers the whole walk, and a one-cycle done pulse closes it. The bus and device counts are parameters, so a small configuration can be swept exhaustively.

Top module: `pci_enum_scanner`

## Requirements
- R1: While reset is high and after it is released, busy_o, done_o, cfg_req_o and rec_valid_o are 0 until a start pulse arrives.
- R2: Slots are visited in ascending order, with the bus as the outer index (0 to 2^BUS_W-1) and the device as the inner index (0 to 2^DEV_W-1). cfg_fn_o is always 0.
- R3: Only one request is outstanding at a time. Once raised, cfg_req_o stays high with bus, device, offset, write flag and write data stable until a cycle in which cfg_rsp_i is 1. cfg_req_o is low in the following cycle.
- R4: Each slot starts with a read of offset 0x00, whose bits 15:0 are the vendor ID and bits 31:16 the device ID. A vendor ID of 0xFFFF ends the slot with no further request and no record.
- R5: For a present device, offset 0x0C is read. rec_hdr_o is bits 23:16 of that dword, and rec_multi_o is bit 23 (bit 7 of the header byte).
- R6: For a present device, offset 0x08 is read. rec_class_o is bits 31:8 and rec_rev_o is bits 7:0.
- R7: For a present device, the per-slot request order is: read 0x00, read 0x0C, read 0x08, then for each BAR index i from 0 to NUM_BARS-1 at offset 0x10+4i: read, write 0xFFFFFFFF, read, write back the value first read. The last request is a read of 0x3C. The only writes ever issued are these BAR writes, so each BAR ends holding its original value.
- R8: A BAR is valid (rec_bar_ok_o bit i = 1) only if its read-back mask is neither 0 nor 0xFFFFFFFF. When bit 0 of the original value is 1, the BAR is I/O (rec_bar_io_o = 1), with base = original & ~3 and size = ~(mask & ~3) + 1. Otherwise the BAR is memory, with ~0xF in place of ~3. An invalid BAR reports base 0, size 0 and both flags 0. Record bits 32i+31:32i hold BAR i.
- R9: rec_irq_o is bits 7:0 of offset 0x3C when that byte lies in 1..31, and 0 otherwise.
- R10: rec_valid_o is a one-cycle pulse in the cycle right after the response to the 0x3C read. done_o is a one-cycle pulse two cycles after the final response of the last slot, and busy_o falls with it.
- R11: start_i has no effect while busy_o is 1. The scan continues without restarting and finishes with exactly one done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a scan when idle |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle end-of-scan pulse |
| cfg_req_o | output | 1 | Configuration request pending |
| cfg_we_o | output | 1 | 1 = write, 0 = read |
| cfg_bus_o | output | BUS_W | Bus number of the request |
| cfg_dev_o | output | DEV_W | Device number of the request |
| cfg_fn_o | output | 3 | Function number (always 0) |
| cfg_reg_o | output | 8 | Byte offset of the dword |
| cfg_wdata_o | output | 32 | Write data |
| cfg_rsp_i | input | 1 | Response / completion strobe |
| cfg_rdata_i | input | 32 | Read data, valid with cfg_rsp_i |
| rec_valid_o | output | 1 | Record strobe |
| rec_bus_o | output | BUS_W | Bus of the record |
| rec_dev_o | output | DEV_W | Device of the record |
| rec_vendor_o | output | 16 | Vendor ID |
| rec_device_o | output | 16 | Device ID |
| rec_class_o | output | 24 | Class code |
| rec_rev_o | output | 8 | Revision |
| rec_hdr_o | output | 8 | Header-type byte |
| rec_multi_o | output | 1 | Multi-function flag |
| rec_irq_o | output | 8 | Filtered interrupt line |
| rec_bar_base_o | output | 32*NUM_BARS | Decoded BAR bases |
| rec_bar_size_o | output | 32*NUM_BARS | Decoded BAR sizes |
| rec_bar_ok_o | output | NUM_BARS | BAR valid flags |
| rec_bar_io_o | output | NUM_BARS | BAR is I/O |

## Verification
The bench models a small configuration space, 2 buses by 4 devices, and answers each request after 0 to 2 extra cycles. It checks every request against the expected order at the moment the request appears. During the wait it confirms the request is held steady. A record is due one cycle after the response to the 0x3C read, and done is due two cycles after the last response. The bench stamps each response with a cycle count and compares the cycle of every strobe against that stamp. It checks record contents and restored BAR values against arithmetic expectations derived from the slot number.

// File: rtl/pci_enum_pkg.sv
package pci_enum_pkg;

  localparam logic [7:0]  OFS_ID    = 8'h00;
  localparam logic [7:0]  OFS_CLASS = 8'h08;
  localparam logic [7:0]  OFS_HDR   = 8'h0C;
  localparam logic [7:0]  OFS_BAR0  = 8'h10;
  localparam logic [7:0]  OFS_IRQ   = 8'h3C;
  localparam logic [15:0] NO_VENDOR = 16'hFFFF;
  localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;
  localparam logic [7:0]  IRQ_MAX   = 8'd31;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_VID,
    ST_HDR,
    ST_CLS,
    ST_BAR_SAVE,
    ST_BAR_ONES,
    ST_BAR_MASK,
    ST_BAR_RESTORE,
    ST_IRQ,
    ST_NEXT
  } scan_state_e;

endpackage

// File: rtl/pci_enum_slot_ctr.sv
module pci_enum_slot_ctr #(
  parameter int BUS_W = 8,
  parameter int DEV_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [BUS_W-1:0] bus_o,
  output logic [DEV_W-1:0] dev_o,
  output logic             last_o
);
  localparam int IDX_W = BUS_W + DEV_W;

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) idx_q <= '0;
    else if (step_i)  idx_q <= idx_q + 1'b1;
  end

  assign {bus_o, dev_o} = idx_q;
  assign last_o         = &idx_q;

  // R2: each step moves to the next slot in bus-major order
  a_r2_slot_step: assert property (@(posedge clk) disable iff (rst)
    (step_i && !clr_i && !last_o) |=> ({bus_o, dev_o} == $past(idx_q) + 1'b1));

endmodule

// File: rtl/pci_enum_bar_decode.sv
module pci_enum_bar_decode (
  input  logic [31:0] orig_i,
  input  logic [31:0] mask_i,
  output logic        ok_o,
  output logic        io_o,
  output logic [31:0] base_o,
  output logic [31:0] size_o
);
  import pci_enum_pkg::*;

  logic [31:0] orig_eff;
  logic [31:0] keep;
  logic        impl;

  always_comb begin
    orig_eff = (orig_i == ALL_ONES) ? '0 : orig_i;
    impl     = (mask_i != '0) && (mask_i != ALL_ONES);
    keep     = orig_eff[0] ? 32'hFFFF_FFFC : 32'hFFFF_FFF0;
    ok_o     = impl;
    io_o     = impl && orig_eff[0];
    base_o   = impl ? (orig_eff & keep) : '0;
    size_o   = impl ? (~(mask_i & keep) + 32'd1) : '0;
  end

endmodule

// File: rtl/pci_enum_bar_bank.sv
module pci_enum_bar_bank #(
  parameter int NUM_BARS = 6,
  parameter int IDX_W    = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_i,
  input  logic                  wr_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic [31:0]           orig_i,
  input  logic [31:0]           mask_i,
  output logic [32*NUM_BARS-1:0] base_o,
  output logic [32*NUM_BARS-1:0] size_o,
  output logic [NUM_BARS-1:0]   ok_o,
  output logic [NUM_BARS-1:0]   io_o
);
  logic        dec_ok;
  logic        dec_io;
  logic [31:0] dec_base;
  logic [31:0] dec_size;

  pci_enum_bar_decode u_dec (
    .orig_i (orig_i),
    .mask_i (mask_i),
    .ok_o   (dec_ok),
    .io_o   (dec_io),
    .base_o (dec_base),
    .size_o (dec_size)
  );

  for (genvar g = 0; g < NUM_BARS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr_i) begin
        base_o[32*g +: 32] <= '0;
        size_o[32*g +: 32] <= '0;
        ok_o[g]            <= 1'b0;
        io_o[g]            <= 1'b0;
      end else if (wr_i && (idx_i == IDX_W'(g))) begin
        base_o[32*g +: 32] <= dec_base;
        size_o[32*g +: 32] <= dec_size;
        ok_o[g]            <= dec_ok;
        io_o[g]            <= dec_io;
      end
    end

    // R8: a valid entry always carries a non-zero size, an invalid one is empty
    a_r8_entry_shape: assert property (@(posedge clk) disable iff (rst)
      ok_o[g] ? (size_o[32*g +: 32] != '0) : ((size_o[32*g +: 32] == '0) && !io_o[g]));
  end

endmodule

// File: rtl/pci_enum_scanner.sv
module pci_enum_scanner #(
  parameter int BUS_W    = 8,
  parameter int DEV_W    = 5,
  parameter int NUM_BARS = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic                   cfg_req_o,
  output logic                   cfg_we_o,
  output logic [BUS_W-1:0]       cfg_bus_o,
  output logic [DEV_W-1:0]       cfg_dev_o,
  output logic [2:0]             cfg_fn_o,
  output logic [7:0]             cfg_reg_o,
  output logic [31:0]            cfg_wdata_o,
  input  logic                   cfg_rsp_i,
  input  logic [31:0]            cfg_rdata_i,
  output logic                   rec_valid_o,
  output logic [BUS_W-1:0]       rec_bus_o,
  output logic [DEV_W-1:0]       rec_dev_o,
  output logic [15:0]            rec_vendor_o,
  output logic [15:0]            rec_device_o,
  output logic [23:0]            rec_class_o,
  output logic [7:0]             rec_rev_o,
  output logic [7:0]             rec_hdr_o,
  output logic                   rec_multi_o,
  output logic [7:0]             rec_irq_o,
  output logic [32*NUM_BARS-1:0] rec_bar_base_o,
  output logic [32*NUM_BARS-1:0] rec_bar_size_o,
  output logic [NUM_BARS-1:0]    rec_bar_ok_o,
  output logic [NUM_BARS-1:0]    rec_bar_io_o
);
  import pci_enum_pkg::*;

  localparam int BAR_IW = (NUM_BARS > 1) ? $clog2(NUM_BARS) : 1;
  localparam logic [BAR_IW-1:0] BAR_LAST = BAR_IW'(NUM_BARS - 1);

  scan_state_e       state_q;
  logic              req_q, we_q, busy_q, done_q, rec_valid_q;
  logic [7:0]        reg_q;
  logic [31:0]       wdata_q;
  logic [BAR_IW-1:0] bar_idx_q;
  logic [31:0]       orig_q;
  logic [15:0]       vendor_q, device_q;
  logic [7:0]        hdr_q, rev_q;
  logic [23:0]       class_q;

  logic              slot_clr, slot_step, slot_last;
  logic [BUS_W-1:0]  slot_bus;
  logic [DEV_W-1:0]  slot_dev;

  logic              rsp_fire, bank_clr, bank_wr, rec_load;
  logic              nxt_we;
  logic [7:0]        nxt_reg;
  logic [31:0]       nxt_wdata;
  logic [7:0]        irq_byte, irq_ok;

  logic [32*NUM_BARS-1:0] bank_base, bank_size;
  logic [NUM_BARS-1:0]    bank_ok, bank_io;

  // ---------------- slot counter ----------------
  assign slot_clr  = (state_q == ST_IDLE) && start_i;
  assign slot_step = (state_q == ST_NEXT) && !slot_last;

  pci_enum_slot_ctr #(.BUS_W(BUS_W), .DEV_W(DEV_W)) u_slot (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (slot_clr),
    .step_i (slot_step),
    .bus_o  (slot_bus),
    .dev_o  (slot_dev),
    .last_o (slot_last)
  );

  // ---------------- request attributes per state ----------------
  always_comb begin
    nxt_we    = 1'b0;
    nxt_reg   = OFS_ID;
    nxt_wdata = '0;
    unique case (state_q)
      ST_HDR:         nxt_reg = OFS_HDR;
      ST_CLS:         nxt_reg = OFS_CLASS;
      ST_BAR_SAVE,
      ST_BAR_MASK:    nxt_reg = OFS_BAR0 + (8'(bar_idx_q) << 2);
      ST_BAR_ONES: begin
        nxt_reg   = OFS_BAR0 + (8'(bar_idx_q) << 2);
        nxt_we    = 1'b1;
        nxt_wdata = ALL_ONES;
      end
      ST_BAR_RESTORE: begin
        nxt_reg   = OFS_BAR0 + (8'(bar_idx_q) << 2);
        nxt_we    = 1'b1;
        nxt_wdata = orig_q;
      end
      ST_IRQ:         nxt_reg = OFS_IRQ;
      default:        nxt_reg = OFS_ID;
    endcase
  end

  assign rsp_fire = req_q && cfg_rsp_i;
  assign bank_clr = rsp_fire && (state_q == ST_VID);
  assign bank_wr  = rsp_fire && (state_q == ST_BAR_MASK);
  assign rec_load = rsp_fire && (state_q == ST_IRQ);

  assign irq_byte = cfg_rdata_i[7:0];
  assign irq_ok   = ((irq_byte != 8'd0) && (irq_byte <= IRQ_MAX)) ? irq_byte : 8'd0;

  // ---------------- sequencer ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      req_q     <= 1'b0;
      we_q      <= 1'b0;
      reg_q     <= '0;
      wdata_q   <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      bar_idx_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            busy_q  <= 1'b1;
            state_q <= ST_VID;
          end
        end
        ST_NEXT: begin
          if (slot_last) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_VID;
          end
        end
        default: begin
          if (!req_q) begin
            req_q   <= 1'b1;
            we_q    <= nxt_we;
            reg_q   <= nxt_reg;
            wdata_q <= nxt_wdata;
          end else if (cfg_rsp_i) begin
            req_q <= 1'b0;
            unique case (state_q)
              ST_VID:      state_q <= (cfg_rdata_i[15:0] == NO_VENDOR) ? ST_NEXT : ST_HDR;
              ST_HDR:      state_q <= ST_CLS;
              ST_CLS: begin
                bar_idx_q <= '0;
                state_q   <= ST_BAR_SAVE;
              end
              ST_BAR_SAVE: state_q <= ST_BAR_ONES;
              ST_BAR_ONES: state_q <= ST_BAR_MASK;
              ST_BAR_MASK: state_q <= ST_BAR_RESTORE;
              ST_BAR_RESTORE: begin
                if (bar_idx_q == BAR_LAST) begin
                  state_q <= ST_IRQ;
                end else begin
                  bar_idx_q <= bar_idx_q + 1'b1;
                  state_q   <= ST_BAR_SAVE;
                end
              end
              default:     state_q <= ST_NEXT;
            endcase
          end
        end
      endcase
    end
  end

  // ---------------- captured device fields ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      vendor_q <= '0;
      device_q <= '0;
      hdr_q    <= '0;
      class_q  <= '0;
      rev_q    <= '0;
      orig_q   <= '0;
    end else if (rsp_fire) begin
      if (state_q == ST_VID) begin
        vendor_q <= cfg_rdata_i[15:0];
        device_q <= cfg_rdata_i[31:16];
      end
      if (state_q == ST_HDR)      hdr_q  <= cfg_rdata_i[23:16];
      if (state_q == ST_CLS) begin
        class_q <= cfg_rdata_i[31:8];
        rev_q   <= cfg_rdata_i[7:0];
      end
      if (state_q == ST_BAR_SAVE) orig_q <= cfg_rdata_i;
    end
  end

  pci_enum_bar_bank #(.NUM_BARS(NUM_BARS), .IDX_W(BAR_IW)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .clr_i  (bank_clr),
    .wr_i   (bank_wr),
    .idx_i  (bar_idx_q),
    .orig_i (orig_q),
    .mask_i (cfg_rdata_i),
    .base_o (bank_base),
    .size_o (bank_size),
    .ok_o   (bank_ok),
    .io_o   (bank_io)
  );

  // ---------------- output record ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid_q    <= 1'b0;
      rec_bus_o      <= '0;
      rec_dev_o      <= '0;
      rec_vendor_o   <= '0;
      rec_device_o   <= '0;
      rec_class_o    <= '0;
      rec_rev_o      <= '0;
      rec_hdr_o      <= '0;
      rec_multi_o    <= 1'b0;
      rec_irq_o      <= '0;
      rec_bar_base_o <= '0;
      rec_bar_size_o <= '0;
      rec_bar_ok_o   <= '0;
      rec_bar_io_o   <= '0;
    end else begin
      rec_valid_q <= rec_load;
      if (rec_load) begin
        rec_bus_o      <= slot_bus;
        rec_dev_o      <= slot_dev;
        rec_vendor_o   <= vendor_q;
        rec_device_o   <= device_q;
        rec_class_o    <= class_q;
        rec_rev_o      <= rev_q;
        rec_hdr_o      <= hdr_q;
        rec_multi_o    <= hdr_q[7];
        rec_irq_o      <= irq_ok;
        rec_bar_base_o <= bank_base;
        rec_bar_size_o <= bank_size;
        rec_bar_ok_o   <= bank_ok;
        rec_bar_io_o   <= bank_io;
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign rec_valid_o = rec_valid_q;
  assign cfg_req_o   = req_q;
  assign cfg_we_o    = we_q;
  assign cfg_reg_o   = reg_q;
  assign cfg_wdata_o = wdata_q;
  assign cfg_bus_o   = slot_bus;
  assign cfg_dev_o   = slot_dev;
  assign cfg_fn_o    = 3'd0;

  // ---------------- assertions ----------------
  // R3: a pending request is held unchanged until its response
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg_req_o && !cfg_rsp_i) |=> (cfg_req_o && $stable(cfg_reg_o) && $stable(cfg_we_o)
      && $stable(cfg_wdata_o) && $stable(cfg_bus_o) && $stable(cfg_dev_o)));

  // R3: the request drops right after being answered
  a_r3_req_drop: assert property (@(posedge clk) disable iff (rst)
    (cfg_req_o && cfg_rsp_i) |=> !cfg_req_o);

  // R7: writes only ever target a BAR dword
  a_r7_write_bar_only: assert property (@(posedge clk) disable iff (rst)
    (cfg_req_o && cfg_we_o) |-> ((cfg_reg_o >= OFS_BAR0) && (cfg_reg_o < OFS_BAR0 + 8'(4*NUM_BARS))
      && (cfg_reg_o[1:0] == 2'b00)));

  // R4: no record for an empty slot
  a_r4_no_empty_record: assert property (@(posedge clk) disable iff (rst)
    rec_valid_o |-> (rec_vendor_o != NO_VENDOR));

  // R9: reported interrupt line is within 0..31
  a_r9_irq_range: assert property (@(posedge clk) disable iff (rst)
    rec_valid_o |-> (rec_irq_o <= IRQ_MAX));

  // R10: done and record strobes last a single cycle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  a_r10_rec_pulse: assert property (@(posedge clk) disable iff (rst)
    rec_valid_o |=> !rec_valid_o);

  // R11: start during a scan does not move the slot pointer back
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && (state_q != ST_NEXT)) |=> ($stable(cfg_bus_o) && $stable(cfg_dev_o)));

endmodule

// File: tb/pci_enum_scanner_tb_top.sv
module pci_enum_scanner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int BW = 1;
  localparam int DW = 2;
  localparam int NS = 8;
  localparam int NB = 6;
  localparam int NPRESENT = 6;

  logic clk = 1'b0;
  logic rst, start_i;
  logic busy_o, done_o, cfg_req_o, cfg_we_o, cfg_rsp_i, rec_valid_o, rec_multi_o;
  logic [BW-1:0] cfg_bus_o, rec_bus_o;
  logic [DW-1:0] cfg_dev_o, rec_dev_o;
  logic [2:0]  cfg_fn_o;
  logic [7:0]  cfg_reg_o, rec_rev_o, rec_hdr_o, rec_irq_o;
  logic [31:0] cfg_wdata_o, cfg_rdata_i;
  logic [15:0] rec_vendor_o, rec_device_o;
  logic [23:0] rec_class_o;
  logic [32*NB-1:0] rec_bar_base_o, rec_bar_size_o;
  logic [NB-1:0] rec_bar_ok_o, rec_bar_io_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pci_enum_scanner #(.BUS_W(BW), .DEV_W(DW), .NUM_BARS(NB)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o), .done_o(done_o),
    .cfg_req_o(cfg_req_o), .cfg_we_o(cfg_we_o), .cfg_bus_o(cfg_bus_o), .cfg_dev_o(cfg_dev_o),
    .cfg_fn_o(cfg_fn_o), .cfg_reg_o(cfg_reg_o), .cfg_wdata_o(cfg_wdata_o),
    .cfg_rsp_i(cfg_rsp_i), .cfg_rdata_i(cfg_rdata_i),
    .rec_valid_o(rec_valid_o), .rec_bus_o(rec_bus_o), .rec_dev_o(rec_dev_o),
    .rec_vendor_o(rec_vendor_o), .rec_device_o(rec_device_o), .rec_class_o(rec_class_o),
    .rec_rev_o(rec_rev_o), .rec_hdr_o(rec_hdr_o), .rec_multi_o(rec_multi_o),
    .rec_irq_o(rec_irq_o), .rec_bar_base_o(rec_bar_base_o), .rec_bar_size_o(rec_bar_size_o),
    .rec_bar_ok_o(rec_bar_ok_o), .rec_bar_io_o(rec_bar_io_o)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int scan_slot, op_j, rec_ptr, rec_count, done_count;
  int last_rsp_cyc, last_irq_cyc;
  bit probe [NS][NB];
  logic [31:0] cur [NS][NB];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  // ---------- configuration space model ----------
  function automatic bit present(int s);
    return (s % 3) != 2;
  endfunction
  function automatic int kind(int s, int i);
    return (s + i) % 4;
  endfunction
  function automatic logic [31:0] bar_orig(int s, int i);
    case (kind(s, i))
      1: return 32'hF000_0008 + (s << 20) + (i << 16);
      2: return 32'h0000_C001 + s * 256 + i * 32;
      3: return 32'h1234_5670;
      default: return 32'h0;
    endcase
  endfunction
  function automatic logic [31:0] bar_mask(int s, int i);
    case (kind(s, i))
      1: return 32'hFFFF_F008;
      2: return 32'hFFFF_FFE1;
      3: return 32'hFFFF_FFFF;
      default: return 32'h0;
    endcase
  endfunction
  function automatic logic [7:0] irq_raw(int s);
    case (s)
      1: return 8'd1;
      3: return 8'd31;
      4: return 8'd32;
      6: return 8'd9;
      7: return 8'd255;
      default: return 8'd0;
    endcase
  endfunction
  function automatic logic [7:0] irq_exp(int s);
    case (s)
      1: return 8'd1;
      3: return 8'd31;
      6: return 8'd9;
      default: return 8'd0;
    endcase
  endfunction
  function automatic logic [7:0] hdr_of(int s);
    return (s % 2 == 1) ? 8'h80 : 8'h00;
  endfunction
  function automatic logic [31:0] class_dw(int s);
    return {8'(8'h02 + s), 8'(8'h10 + s), 8'(8'h20 + s), 8'(s * 7)};
  endfunction

  task automatic exp_op(input int s, input int j, output bit we, output logic [7:0] rg,
                        output logic [31:0] wd);
    we = 1'b0; wd = '0;
    if (j == 0) rg = 8'h00;
    else if (j == 1) rg = 8'h0C;
    else if (j == 2) rg = 8'h08;
    else if (j == 27) rg = 8'h3C;
    else begin
      rg = 8'(8'h10 + 4 * ((j - 3) / 4));
      case ((j - 3) % 4)
        1: begin we = 1'b1; wd = 32'hFFFF_FFFF; end
        3: begin we = 1'b1; wd = bar_orig(s, (j - 3) / 4); end
        default: ;
      endcase
    end
  endtask

  // ---------- responder ----------
  initial begin
    cfg_rsp_i = 1'b0;
    cfg_rdata_i = '0;
    forever begin
      @(negedge clk);
      cfg_rsp_i = 1'b0;
      if (cfg_req_o && !rst) begin
        automatic int s = int'(cfg_bus_o) * 4 + int'(cfg_dev_o);
        automatic logic [7:0] rg = cfg_reg_o;
        automatic bit we = cfg_we_o;
        automatic logic [31:0] wd = cfg_wdata_o;
        automatic bit e_we;
        automatic logic [7:0] e_rg;
        automatic logic [31:0] e_wd;
        automatic int lat = (s + op_j) % 3;
        automatic bit held = 1'b1;
        automatic logic [31:0] data = 32'hFFFF_FFFF;
        exp_op(scan_slot, op_j, e_we, e_rg, e_wd);
        check(s == scan_slot && cfg_fn_o == 3'd0, "R2", "slot order", 32'(s), 32'(scan_slot));
        check(rg == e_rg && we == e_we && (!we || wd == e_wd), "R7", "request sequence",
              {16'(op_j), 7'd0, we, rg}, {16'(op_j), 7'd0, e_we, e_rg});
        for (int l = 0; l < lat; l++) begin
          @(negedge clk);
          if (!(cfg_req_o && cfg_reg_o == rg && cfg_we_o == we && cfg_wdata_o == wd)) held = 1'b0;
        end
        check(held, "R3", "request held until response", 32'(held), 32'd1);
        if (present(s)) begin
          if (rg >= 8'h10 && rg < 8'h28 && rg[1:0] == 2'b00) begin
            automatic int b = (int'(rg) - 16) / 4;
            if (we) begin
              if (wd == 32'hFFFF_FFFF) probe[s][b] = 1'b1;
              else begin probe[s][b] = 1'b0; cur[s][b] = wd; end
            end
            data = probe[s][b] ? bar_mask(s, b) : cur[s][b];
          end else if (rg == 8'h00) data = {16'(16'h8000 + s * 3), 16'(16'h1000 + s)};
          else if (rg == 8'h08) data = class_dw(s);
          else if (rg == 8'h0C) data = {8'h00, hdr_of(s), 8'h00, 8'h10};
          else if (rg == 8'h3C) data = 32'hAB00_0100 | 32'(irq_raw(s));
          else data = 32'h0;
        end
        cfg_rdata_i = data;
        cfg_rsp_i = 1'b1;
        last_rsp_cyc = cyc;
        if (rg == 8'h3C && !we) last_irq_cyc = cyc;
        if ((op_j == 0 && !present(scan_slot)) || op_j == 27) begin
          scan_slot++;
          op_j = 0;
        end else op_j++;
      end
    end
  end

  // ---------- record / done monitor ----------
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && rec_valid_o) begin
        automatic int s;
        rec_count++;
        while (rec_ptr < NS && !present(rec_ptr)) rec_ptr++;
        s = rec_ptr;
        rec_ptr++;
        check(cyc == last_irq_cyc + 1, "R10", "record one cycle after irq response",
              32'(cyc), 32'(last_irq_cyc + 1));
        check({rec_bus_o, rec_dev_o} == 3'(s), "R2", "record slot", 32'({rec_bus_o, rec_dev_o}), 32'(s));
        check(rec_vendor_o == 16'(16'h1000 + s) && rec_device_o == 16'(16'h8000 + s * 3), "R4",
              "ids", {rec_device_o, rec_vendor_o}, {16'(16'h8000 + s * 3), 16'(16'h1000 + s)});
        check(rec_hdr_o == hdr_of(s) && rec_multi_o == s[0], "R5", "header/multi",
              {23'd0, rec_multi_o, rec_hdr_o}, {23'd0, s[0], hdr_of(s)});
        check({rec_class_o, rec_rev_o} == class_dw(s), "R6", "class/rev",
              {rec_class_o, rec_rev_o}, class_dw(s));
        check(rec_irq_o == irq_exp(s), "R9", "irq line", 32'(rec_irq_o), 32'(irq_exp(s)));
        for (int i = 0; i < NB; i++) begin
          automatic int k = kind(s, i);
          automatic logic [31:0] eb = (k == 1) ? 32'hF000_0000 + (s << 20) + (i << 16) :
                                      (k == 2) ? 32'h0000_C000 + s * 256 + i * 32 : 32'h0;
          automatic logic [31:0] es = (k == 1) ? 32'h1000 : (k == 2) ? 32'h20 : 32'h0;
          automatic bit eok = (k == 1) || (k == 2);
          automatic bit eio = (k == 2);
          check(rec_bar_base_o[32*i +: 32] == eb && rec_bar_size_o[32*i +: 32] == es
                && rec_bar_ok_o[i] == eok && rec_bar_io_o[i] == eio, "R8", $sformatf("bar%0d base", i),
                rec_bar_base_o[32*i +: 32], eb);
        end
      end
      if (!rst && done_o) begin
        done_count++;
        check(cyc == last_rsp_cyc + 2 && scan_slot == NS, "R10", "done timing",
              32'(cyc), 32'(last_rsp_cyc + 2));
      end
    end
  end

  // ---------- scan runner ----------
  task automatic run_scan(input bit poke_start, output bit timed_out);
    automatic int waited = 0;
    scan_slot = 0; op_j = 0; rec_ptr = 0; rec_count = 0; done_count = 0;
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < NB; i++) begin
        probe[s][i] = 1'b0;
        cur[s][i] = bar_orig(s, i);
      end
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    check(busy_o == 1'b1, "R10", "busy after start", 32'(busy_o), 32'd1);
    if (poke_start) begin
      repeat (150) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (300) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    while (done_count == 0 && waited < 50000) begin
      @(negedge clk);
      waited++;
    end
    timed_out = (done_count == 0);
    repeat (20) @(negedge clk);
    check(!timed_out, "R10", "watchdog: scan finished", 32'(done_count), 32'd1);
    check(done_count == 1, "R11", "exactly one done", 32'(done_count), 32'd1);
    check(rec_count == NPRESENT, "R4", "records only for present slots", 32'(rec_count), NPRESENT);
    check(busy_o == 1'b0, "R10", "busy low after done", 32'(busy_o), 32'd0);
    check(scan_slot == NS, "R2", "all slots visited", 32'(scan_slot), NS);
    for (int s = 0; s < NS; s++)
      for (int i = 0; i < NB; i++)
        if (present(s))
          check(!probe[s][i] && cur[s][i] == bar_orig(s, i), "R7", $sformatf("bar restored s%0d", s),
                cur[s][i], bar_orig(s, i));
  endtask

  initial begin
    automatic bit to = 1'b0;
    rst = 1'b1;
    start_i = 1'b0;
    last_rsp_cyc = 0;
    last_irq_cyc = 0;
    repeat (4) @(negedge clk);
    check(!busy_o && !done_o && !cfg_req_o && !rec_valid_o, "R1", "outputs in reset",
          {28'd0, busy_o, done_o, cfg_req_o, rec_valid_o}, 32'd0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(!busy_o && !done_o && !cfg_req_o && !rec_valid_o, "R1", "idle after reset",
          {28'd0, busy_o, done_o, cfg_req_o, rec_valid_o}, 32'd0);
    run_scan(1'b1, to);
    if (!to) run_scan(1'b0, to);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule